// File: doc/BRIEF.md
# Dual-Bank Firmware Store with Atomic Swap

This block keeps two program stores for a small embedded sequencer. While the sequencer fetches instructions from one store (the active bank), a host can load a new program into the other (the idle bank) through a single-beat register-style port. Downloading therefore runs in parallel with execution.

When the host asks for a swap, the request waits for the sequencer's next instruction fetch. In the cycle after that fetch, the banks trade roles. The block then holds the sequencer in reset for two cycles, and the sequencer restarts at word 0 of the newly active bank. The active bank is protected: a host write aimed at it is discarded and recorded in a sticky error flag. The host can read both banks and a status word at any time.

Each bank holds 4096 words of 18 bits. The host sees each word as one 32-bit register whose upper bits read as zero. The sequencer's interrupt entry at word 1023 is an ordinary word of the active bank. It is loaded and fetched like every other word.

Top module: `fw_dual_bank`

## Requirements
- R1: After reset, bank 0 is active. No swap is pending, the error flag is clear, `seq_rst` is low and `host_rvalid` is low.
- R2: The host address has three fields. Bit 13 is the space (0 = program words, 1 = control), bit 12 selects the bank and bits 11:0 give the word index. A read strobe with no write strobe in the same cycle produces `host_rvalid` one cycle later. For a program word, `host_rdata` then carries the word in bits 17:0 and zeros in bits 31:18.
- R3: A host write to the idle bank stores `host_wdata[17:0]` at the addressed word. A host write to the active bank leaves that bank's contents unchanged.
- R4: A host write to the active bank sets a sticky error flag, reported in status bit 2. The flag stays set until a control-space write with data bit 1 set clears it.
- R5: When `seq_fetch_en` is high, `seq_instr` in the next cycle holds the word at `seq_fetch_addr` in the bank that was active in the fetch cycle. `seq_instr` holds its value when no fetch occurs.
- R6: A control-space write with data bit 0 set raises the swap-pending flag, reported in status bit 1. The flag persists through cycles without a fetch. A further request while one is pending has no additional effect.
- R7: A pending swap is taken in a cycle where `seq_fetch_en` is high and `seq_rst` is low. In the next cycle, the active bank (status bit 0) flips, pending clears, and `seq_rst` is high for exactly two cycles. A fetch of word 0 afterwards returns the new bank's word 0.
- R8: Host writes to the idle bank, issued in the same cycles as sequencer fetches, do not disturb the fetched instructions.
- R9: When the write and read strobes are both high in one cycle, the write is carried out and no read response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 14 | Host address: space, bank, word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe |
| seq_fetch_en | input | 1 | Sequencer fetch strobe (instruction boundary) |
| seq_fetch_addr | input | 12 | Sequencer fetch word index |
| seq_instr | output | 18 | Fetched instruction word |
| seq_rst | output | 1 | Reset hold to the sequencer after a swap |

## Verification
The hazardous overlap is a host write landing in the very cycle the pending swap is taken at a fetch. The write targets the bank that is about to become active. The bench issues both in one cycle. It expects that the protection check uses the roles that held before the flip, so the write is stored and the error flag stays clear. It then confirms this by fetching word 0 after the two-cycle reset and reading the status word. A second overlap, a fetch from the active bank during a write to the idle bank, is run back to back over several addresses. Each fetched word and each stored word are compared against the bench's own model.

// File: rtl/fwsw_pkg.sv
package fwsw_pkg;
  // control-space write data bits
  localparam int unsigned CTL_SWAP_BIT = 0;
  localparam int unsigned CTL_CLR_BIT  = 1;
  // status word layout: bit0 active bank, bit1 pending, bit2 error
  typedef struct packed {
    logic err;
    logic pending;
    logic active;
  } fwsw_status_t;
endpackage

// File: rtl/fwsw_bank_ram.sv
module fwsw_bank_ram #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // host port: read-first, write gated
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // sequencer port: read only, enabled per fetch
  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/fwsw_swap_ctrl.sv
module fwsw_swap_ctrl #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic swap_req,
  input  logic err_clr,
  input  logic bad_wr,
  input  logic fetch_en,
  output logic active,
  output logic pending,
  output logic err,
  output logic seq_rst
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] hold_cnt;
  logic          take;

  assign take = pending && fetch_en && !seq_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      pending  <= 1'b0;
      hold_cnt <= '0;
      seq_rst  <= 1'b0;
    end else begin
      if (take) begin
        active   <= ~active;
        pending  <= 1'b0;
        hold_cnt <= CW'(HOLD - 1);
      end else begin
        if (swap_req) pending <= 1'b1;
        if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      end
      seq_rst <= take || (hold_cnt != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err <= 1'b0;
    else if (err_clr) err <= 1'b0;
    else if (bad_wr)  err <= 1'b1;
  end

  a_r7_take_flips: assert property (@(posedge clk) disable iff (rst)
    (pending && fetch_en && !seq_rst) |=> (active != $past(active)) && !pending && seq_rst);

  a_r6_flip_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    (active != $past(active)) |-> $past(pending && fetch_en));

  a_r6_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (pending && !fetch_en) |=> pending);

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);

  generate
    if (HOLD == 2) begin : g_hold_chk
      a_r7_hold_two: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_rst) |=> seq_rst ##1 !seq_rst);
    end
  endgenerate
endmodule

// File: rtl/fw_dual_bank.sv
module fw_dual_bank #(
  parameter int unsigned WORD_AW  = 12,
  parameter int unsigned INSTR_W  = 18,
  parameter int unsigned HOST_DW  = 32,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_we,
  input  logic                    host_re,
  input  logic [WORD_AW+1:0]      host_addr,
  input  logic [HOST_DW-1:0]      host_wdata,
  output logic [HOST_DW-1:0]      host_rdata,
  output logic                    host_rvalid,
  input  logic                    seq_fetch_en,
  input  logic [WORD_AW-1:0]      seq_fetch_addr,
  output logic [INSTR_W-1:0]      seq_instr,
  output logic                    seq_rst
);
  import fwsw_pkg::*;

  localparam int unsigned BANK_BIT  = WORD_AW;
  localparam int unsigned SPACE_BIT = WORD_AW + 1;
  localparam int unsigned NBANK     = 2;
  localparam int unsigned ST_W      = $bits(fwsw_status_t);

  logic               is_ctrl, tgt_bank, mem_wr, bad_wr, swap_req, err_clr;
  logic [WORD_AW-1:0] idx;
  fwsw_status_t       st, st_q;
  logic               rd_q, rd_ctrl_q, rd_bank_q, fetch_sel_q;
  logic [INSTR_W-1:0] a_rd [NBANK];
  logic [INSTR_W-1:0] b_rd [NBANK];

  assign is_ctrl  = host_addr[SPACE_BIT];
  assign tgt_bank = host_addr[BANK_BIT];
  assign idx      = host_addr[WORD_AW-1:0];
  assign mem_wr   = host_we && !is_ctrl;
  assign bad_wr   = mem_wr && (tgt_bank == st.active);
  assign swap_req = host_we && is_ctrl && host_wdata[CTL_SWAP_BIT];
  assign err_clr  = host_we && is_ctrl && host_wdata[CTL_CLR_BIT];

  fwsw_swap_ctrl #(.HOLD(HOLD_CYC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .swap_req (swap_req),
    .err_clr  (err_clr),
    .bad_wr   (bad_wr),
    .fetch_en (seq_fetch_en),
    .active   (st.active),
    .pending  (st.pending),
    .err      (st.err),
    .seq_rst  (seq_rst)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic bank_we;
      assign bank_we = mem_wr && !bad_wr && (tgt_bank == 1'(b));
      fwsw_bank_ram #(.AW(WORD_AW), .DW(INSTR_W)) u_ram (
        .clk     (clk),
        .a_we    (bank_we),
        .a_addr  (idx),
        .a_wdata (host_wdata[INSTR_W-1:0]),
        .a_rdata (a_rd[b]),
        .b_en    (seq_fetch_en),
        .b_addr  (seq_fetch_addr),
        .b_rdata (b_rd[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= 1'b0;
      rd_ctrl_q   <= 1'b0;
      rd_bank_q   <= 1'b0;
      st_q        <= '0;
      fetch_sel_q <= 1'b0;
    end else begin
      rd_q      <= host_re && !host_we;
      rd_ctrl_q <= is_ctrl;
      rd_bank_q <= tgt_bank;
      st_q      <= st;
      if (seq_fetch_en) fetch_sel_q <= st.active;
    end
  end

  assign host_rvalid = rd_q;
  assign host_rdata  = rd_ctrl_q ? {{(HOST_DW-ST_W){1'b0}}, st_q}
                                 : {{(HOST_DW-INSTR_W){1'b0}}, a_rd[rd_bank_q]};
  assign seq_instr   = b_rd[fetch_sel_q];

  a_r9_rvalid_src: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_re && !host_we));

  a_r3_no_rsp_on_write: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_re) |=> !host_rvalid);
endmodule

// File: tb/fw_dual_bank_tb.sv
`timescale 1ns/1ps
module fw_dual_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [13:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        seq_fetch_en = 1'b0;
  logic [11:0] seq_fetch_addr = '0;
  logic [17:0] seq_instr;
  logic        seq_rst;

  always #2.5 clk = ~clk;

  fw_dual_bank u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .seq_fetch_en(seq_fetch_en),
    .seq_fetch_addr(seq_fetch_addr), .seq_instr(seq_instr), .seq_rst(seq_rst)
  );

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t rq[$];

  int tests = 0, fails = 0;
  logic [17:0] mdl [2][4096];
  bit m_act = 0, m_pend = 0, m_err = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read responses
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (rq.size() == 0) check("R2 unexpected response", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = rq.pop_front();
        check(e.tag, host_rdata, e.exp);
      end
    end
  end

  function automatic logic [31:0] status_exp();
    return {29'd0, m_err, m_pend, m_act};
  endfunction

  // one cycle of stimulus with model bookkeeping
  task automatic cyc(input bit f, input logic [11:0] fa,
                     input bit w, input logic [13:0] wa, input logic [31:0] wd,
                     input bit r, input logic [13:0] ra, input string tag);
    logic [17:0] fexp;
    bit take;
    if (r && !w) begin
      exp_t e;
      e.tag = tag;
      e.exp = ra[13] ? status_exp() : {14'd0, mdl[ra[12]][ra[11:0]]};
      rq.push_back(e);
    end
    fexp = mdl[m_act][fa];
    take = f && m_pend;
    if (w) begin
      if (wa[13]) begin
        if (wd[1]) m_err = 0;
        if (wd[0]) m_pend = 1;
      end else if (wa[12] == m_act) m_err = 1;
      else mdl[wa[12]][wa[11:0]] = wd[17:0];
    end
    seq_fetch_en = f; seq_fetch_addr = fa;
    host_we = w; host_re = r;
    host_addr = w ? wa : ra; host_wdata = wd;
    @(negedge clk);
    seq_fetch_en = 0; host_we = 0; host_re = 0;
    if (f && !$isunknown(fexp)) check({tag, " R5 fetch"}, {14'd0, seq_instr}, {14'd0, fexp});
    if (w && r) check("R9 no response", {31'd0, host_rvalid}, 32'd0);
    if (take) begin
      m_act = ~m_act; m_pend = 0;
      check("R7 reset cycle 1", {31'd0, seq_rst}, 32'd1);
      @(negedge clk);
      check("R7 reset cycle 2", {31'd0, seq_rst}, 32'd1);
      @(negedge clk);
      check("R7 reset released", {31'd0, seq_rst}, 32'd0);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    cyc(0, '0, 1, a, d, 0, '0, "wr");
  endtask
  task automatic rd(input logic [13:0] a, input string tag);
    cyc(0, '0, 0, '0, '0, 1, a, tag);
  endtask
  task automatic fetch(input logic [11:0] a, input string tag);
    cyc(1, a, 0, '0, '0, 0, '0, tag);
  endtask

  function automatic logic [13:0] ma(input bit bank, input int i);
    return {1'b0, bank, 12'(i)};
  endfunction
  localparam logic [13:0] CTL = 14'h2000;

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 4096; i++) mdl[b][i] = 'x;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rvalid", {31'd0, host_rvalid}, 32'd0);
    check("R1 seq_rst", {31'd0, seq_rst}, 32'd0);
    rd(CTL, "R1 status");
    // R2/R3 writes to idle bank 1, including word 1023 and the last word
    wr(ma(1, 0), 32'hABCD_1234);
    wr(ma(1, 1023), 32'hFFFF_FFFF);
    wr(ma(1, 4095), 32'h0002_AAAA);
    wr(ma(1, 5), 32'h0001_5555);
    rd(ma(1, 0), "R2 word0 upper zero");
    rd(ma(1, 1023), "R2 word1023");
    rd(ma(1, 4095), "R3 last word");
    rd(ma(1, 5), "R3 word5");
    // R4 write to active bank 0 flags error
    wr(ma(0, 7), 32'h1111);
    rd(CTL, "R4 error set");
    // R6 swap request and hold
    wr(CTL, 32'h1);
    rd(CTL, "R6 pending");
    repeat (3) @(negedge clk);
    rd(CTL, "R6 pending held");
    wr(CTL, 32'h1);
    // R7 take at fetch
    fetch(12'd5, "R7 take");
    rd(CTL, "R7 status after swap");
    fetch(12'd0, "R7 restart word0");
    fetch(12'd1023, "R5 interrupt word");
    fetch(12'd4095, "R5 last word");
    // R4 clear
    wr(CTL, 32'h2);
    rd(CTL, "R4 error cleared");
    // R8 parallel download to bank 0 with fetches from bank 1
    for (int i = 0; i < 6; i++)
      cyc(1, (i % 2) ? 12'd1023 : 12'd5, 1, ma(0, i), 32'h0003_0000 + 32'(i * 37), 0, '0, "R8 parallel");
    for (int i = 0; i < 6; i++) rd(ma(0, i), "R8 readback");
    // R3 dropped write to active bank 1
    wr(ma(1, 0), 32'h0000_0BAD);
    rd(ma(1, 0), "R3 active unchanged");
    rd(CTL, "R4 error on active write");
    wr(CTL, 32'h2);
    // R9 write and read in one cycle
    cyc(0, '0, 1, ma(0, 9), 32'h0002_4242, 1, ma(0, 9), "R9");
    rd(ma(0, 9), "R9 write landed");
    // same-cycle swap take and write to the bank about to become active
    wr(CTL, 32'h1);
    cyc(1, 12'd5, 1, ma(0, 0), 32'h0001_C0DE, 0, '0, "R7 overlap");
    rd(CTL, "R7 overlap status");
    fetch(12'd0, "R7 overlap word0");
    // after swap back, bank 0 active: write to it dropped
    wr(ma(0, 9), 32'h0000_0001);
    rd(ma(0, 9), "R3 protected bank0");
    rd(CTL, "R4 error after swap back");
    repeat (3) @(negedge clk);
    check("R2 responses drained", 32'(rq.size()), 32'd0);
    report();
  end
endmodule